// File: doc/BRIEF.md
# Serially Probed Pseudo-Associative Cache

This block is a cache that keeps all of its lines in one single-ported, direct-mapped storage array. It still behaves like a set-associative cache with BANKS ways. The array is split into BANKS banks, and each bank holds SETS = LINES/BANKS sets. A lookup does not compare all ways at once. It re-reads the same array once per bank, each time with a different bank number placed above the set index. It starts at bank 0 and stops at the first bank whose stored tag matches. A hit in a low bank is therefore faster than a hit in a high bank. Every response reports how many probes the lookup needed.

A processor side issues one request at a time through a valid/ready handshake and receives a one-cycle response pulse. Reads that miss in every bank fetch the line through a fill port. The fetched line goes into the first empty bank of its set, or into a per-set round-robin victim once all banks are full. Writes are write-through and never allocate a line. When enabled, a read that hits beyond bank 0 swaps its line with the one in bank 0, so that a repeated access costs a single probe.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, fill_req_valid and mem_wr_valid are 0. Every line is invalid, so the first read of any address misses.
- R2: The set index is the low log2(SETS) bits of the line address, and the stored tag is all address bits above it. Probe i reads array line {i, set}, that is, i*SETS + set.
- R3: Probes visit banks 0, 1, ... in order, one per cycle, and the first matching bank ends the lookup. A hit in bank b raises rsp_valid exactly b+1 cycles after the request is accepted, with rsp_hit=1 and rsp_probes=b+1.
- R4: A read that misses in all banks raises fill_req_valid after the last probe. fill_req_addr equals the request address, and both stay stable until fill_rsp_valid. The response then carries rsp_hit=0, rsp_probes=BANKS and the returned fill data.
- R5: A fill is written into the lowest-numbered invalid bank of the set. If all banks are valid, the fill goes into the bank named by a per-set round-robin pointer, which then advances by one (modulo BANKS).
- R6: With SWAP_EN=1, a read hit in bank b>0 swaps the contents of banks 0 and b of that set. req_ready is 0 for the two cycles after that response.
- R7: A write probes like a read, then emits a one-cycle mem_wr_valid with the request address and data in the same cycle as its response. On a hit it updates the stored data in place. On a miss it reports rsp_hit=0 and rsp_probes=BANKS and starts no fill.
- R8: req_ready is 1 only when no request is in progress. Otherwise it is 0. It is 1 in the cycle a response appears, except after a swapping hit. rsp_valid lasts a single cycle.
- R9: The data returned by a read equals the last value written to that address through the block, or the next-level value if the address was never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Lookup hit in some bank |
| rsp_probes | output | PROBE_W | Number of probes the lookup used |
| rsp_data | output | DATA_W | Read data (write data echoed for writes) |
| fill_req_valid | output | 1 | Line fetch request, held until answered |
| fill_req_addr | output | ADDR_W | Address to fetch |
| fill_rsp_valid | input | 1 | Fetched data present |
| fill_rsp_data | input | DATA_W | Fetched data |
| mem_wr_valid | output | 1 | Write-through strobe |
| mem_wr_addr | output | ADDR_W | Write-through address |
| mem_wr_data | output | DATA_W | Write-through data |

## Verification
The bench builds the cache with LINES=16, BANKS=4 and ADDR_W=8, which gives four sets of four banks. A sweep that keeps to eight tags per set then forces constant conflicts: every bank position is hit, and both round-robin replacement and swapping occur many times in every set. The expected probe count, hit flag, latency and data for each access come from a small bench-side placement table and a memory image. A directed prologue walks one set through cold fills, swaps, replacement and write hit and miss.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_FILL,
    ST_SWAP_A,
    ST_SWAP_B
  } cpa_state_e;
endpackage

// File: rtl/cpa_store.sv
// Single-port line array with synchronous read (block RAM friendly).
module cpa_store #(
  parameter int ENTRIES = 64,
  parameter int WIDTH   = 42,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cpa_victim.sv
// Valid bits per line and per-set round-robin pointers; picks the fill bank.
module cpa_victim #(
  parameter int BANKS  = 4,
  parameter int SETS   = 16,
  localparam int BANK_W = $clog2(BANKS),
  localparam int SET_W  = $clog2(SETS),
  localparam int LINES  = BANKS * SETS,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] lk_line,
  output logic              lk_valid,
  input  logic [SET_W-1:0]  fill_set,
  input  logic              fill_en,
  output logic [BANK_W-1:0] fill_bank
);
  logic [LINES-1:0]  vld;
  logic [BANK_W-1:0] rr [SETS];
  logic              found;
  logic [BANK_W-1:0] pick;

  assign lk_valid = vld[lk_line];

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (!found && !vld[{BANK_W'(b), fill_set}]) begin
        found = 1'b1;
        pick  = BANK_W'(b);
      end
    end
    if (!found) pick = rr[fill_set];
  end

  assign fill_bank = pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (fill_en) begin
      vld[{pick, fill_set}] <= 1'b1;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_rr
    always_ff @(posedge clk) begin
      if (rst) begin
        rr[s] <= '0;
      end else if (fill_en && !found && fill_set == SET_W'(s)) begin
        rr[s] <= rr[s] + BANK_W'(1);
      end
    end
  end

  // R5: a fill never lands on an invalid line other than the lowest one
  a_r5_fill_lowest_free: assert property (@(posedge clk) disable iff (rst)
    (fill_en && found) |-> (pick == '0 || vld[{pick - BANK_W'(1), fill_set}]));
endmodule

// File: rtl/cpa_ctrl.sv
// Serial probe sequencer: request handshake, probing, fill, swap, write-through.
module cpa_ctrl
  import cpa_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int SETS    = 16,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter bit SWAP_EN = 1'b1,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int SET_W   = $clog2(SETS),
  localparam int LINE_W  = BANK_W + SET_W,
  localparam int TAG_W   = ADDR_W - SET_W,
  localparam int ENTRY_W = TAG_W + DATA_W,
  localparam int PROBE_W = $clog2(BANKS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [PROBE_W-1:0] rsp_probes,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               fill_req_valid,
  output logic [ADDR_W-1:0]  fill_req_addr,
  input  logic               fill_rsp_valid,
  input  logic [DATA_W-1:0]  fill_rsp_data,
  output logic               mem_wr_valid,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [DATA_W-1:0]  mem_wr_data,
  output logic               ram_we,
  output logic [LINE_W-1:0]  ram_addr,
  output logic [ENTRY_W-1:0] ram_wdata,
  input  logic [ENTRY_W-1:0] ram_rdata,
  output logic [LINE_W-1:0]  lk_line,
  input  logic               lk_valid,
  output logic [SET_W-1:0]   vfill_set,
  output logic               vfill_en,
  input  logic [BANK_W-1:0]  vfill_bank
);
  cpa_state_e        st;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_write;
  logic [DATA_W-1:0] cur_wdata;
  logic [BANK_W-1:0] probe;
  logic [BANK_W-1:0] hit_bank;
  logic [DATA_W-1:0] hit_data;
  logic [ENTRY_W-1:0] save0;

  logic [SET_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;
  logic [TAG_W-1:0]  r_tag;
  logic [DATA_W-1:0] r_data;
  logic              probe_hit;
  logic              last_probe;

  assign cur_set    = cur_addr[SET_W-1:0];
  assign cur_tag    = cur_addr[ADDR_W-1:SET_W];
  assign r_tag      = ram_rdata[ENTRY_W-1:DATA_W];
  assign r_data     = ram_rdata[DATA_W-1:0];
  assign lk_line    = {probe, cur_set};
  assign probe_hit  = (st == ST_PROBE) && lk_valid && (r_tag == cur_tag);
  assign last_probe = (probe == BANK_W'(BANKS - 1));
  assign req_ready  = (st == ST_IDLE);
  assign vfill_set  = cur_set;
  assign vfill_en   = (st == ST_FILL) && fill_rsp_valid;

  // Array port steering: one access per cycle.
  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = {BANK_W'(0), req_addr[SET_W-1:0]};
    ram_wdata = {cur_tag, cur_wdata};
    unique case (st)
      ST_IDLE: ;
      ST_PROBE: begin
        if (probe_hit && cur_write) begin
          ram_we   = 1'b1;
          ram_addr = {probe, cur_set};
        end else begin
          ram_addr = {probe + BANK_W'(1), cur_set};
        end
      end
      ST_FILL: begin
        ram_we    = fill_rsp_valid;
        ram_addr  = {vfill_bank, cur_set};
        ram_wdata = {cur_tag, fill_rsp_data};
      end
      ST_SWAP_A: begin
        ram_we    = 1'b1;
        ram_addr  = {BANK_W'(0), cur_set};
        ram_wdata = {cur_tag, hit_data};
      end
      ST_SWAP_B: begin
        ram_we    = 1'b1;
        ram_addr  = {hit_bank, cur_set};
        ram_wdata = save0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      cur_addr       <= '0;
      cur_write      <= 1'b0;
      cur_wdata      <= '0;
      probe          <= '0;
      hit_bank       <= '0;
      hit_data       <= '0;
      save0          <= '0;
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_probes     <= '0;
      rsp_data       <= '0;
      fill_req_valid <= 1'b0;
      fill_req_addr  <= '0;
      mem_wr_valid   <= 1'b0;
      mem_wr_addr    <= '0;
      mem_wr_data    <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      mem_wr_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr  <= req_addr;
            cur_write <= req_write;
            cur_wdata <= req_wdata;
            probe     <= '0;
            st        <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (probe == '0) save0 <= ram_rdata;
          if (probe_hit) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b1;
            rsp_probes <= PROBE_W'(probe) + PROBE_W'(1);
            rsp_data   <= cur_write ? cur_wdata : r_data;
            if (cur_write) begin
              mem_wr_valid <= 1'b1;
              mem_wr_addr  <= cur_addr;
              mem_wr_data  <= cur_wdata;
              st           <= ST_IDLE;
            end else if (SWAP_EN && probe != '0) begin
              hit_bank <= probe;
              hit_data <= r_data;
              st       <= ST_SWAP_A;
            end else begin
              st <= ST_IDLE;
            end
          end else if (!last_probe) begin
            probe <= probe + BANK_W'(1);
          end else if (cur_write) begin
            rsp_valid    <= 1'b1;
            rsp_hit      <= 1'b0;
            rsp_probes   <= PROBE_W'(BANKS);
            rsp_data     <= cur_wdata;
            mem_wr_valid <= 1'b1;
            mem_wr_addr  <= cur_addr;
            mem_wr_data  <= cur_wdata;
            st           <= ST_IDLE;
          end else begin
            fill_req_valid <= 1'b1;
            fill_req_addr  <= cur_addr;
            st             <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_rsp_valid) begin
            fill_req_valid <= 1'b0;
            rsp_valid      <= 1'b1;
            rsp_hit        <= 1'b0;
            rsp_probes     <= PROBE_W'(BANKS);
            rsp_data       <= fill_rsp_data;
            st             <= ST_IDLE;
          end
        end
        ST_SWAP_A: st <= ST_SWAP_B;
        ST_SWAP_B: st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  // R8: the response strobe lasts one cycle
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8: no new request is taken while a fill is outstanding
  a_r8_busy_on_fill: assert property (@(posedge clk) disable iff (rst)
    fill_req_valid |-> !req_ready);

  // R4: the fill request and its address hold until answered
  a_r4_fill_hold: assert property (@(posedge clk) disable iff (rst)
    (fill_req_valid && !fill_rsp_valid) |=> (fill_req_valid && $stable(fill_req_addr)));

  // R4 / R7: a missing lookup has used every bank
  a_r4_miss_probes: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_probes == PROBE_W'(BANKS)));

  // R3: the reported probe count lies within 1..BANKS
  a_r3_probe_range: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_probes != '0 && rsp_probes <= PROBE_W'(BANKS)));

  // R7: write-through strobe coincides with a response
  a_r7_wr_with_rsp: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> rsp_valid);

  // R6: a swapping read hit keeps the request side closed for two cycles
  a_r6_swap_busy: assert property (@(posedge clk) disable iff (rst)
    (SWAP_EN && rsp_valid && rsp_hit && !mem_wr_valid && rsp_probes > PROBE_W'(1))
      |-> (!req_ready ##1 !req_ready));
endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache #(
  parameter int LINES   = 64,
  parameter int BANKS   = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter bit SWAP_EN = 1'b1,
  localparam int SETS    = LINES / BANKS,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int SET_W   = $clog2(SETS),
  localparam int LINE_W  = BANK_W + SET_W,
  localparam int TAG_W   = ADDR_W - SET_W,
  localparam int ENTRY_W = TAG_W + DATA_W,
  localparam int PROBE_W = $clog2(BANKS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [PROBE_W-1:0] rsp_probes,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               fill_req_valid,
  output logic [ADDR_W-1:0]  fill_req_addr,
  input  logic               fill_rsp_valid,
  input  logic [DATA_W-1:0]  fill_rsp_data,
  output logic               mem_wr_valid,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [DATA_W-1:0]  mem_wr_data
);
  logic               ram_we;
  logic [LINE_W-1:0]  ram_addr;
  logic [ENTRY_W-1:0] ram_wdata;
  logic [ENTRY_W-1:0] ram_rdata;
  logic [LINE_W-1:0]  lk_line;
  logic               lk_valid;
  logic [SET_W-1:0]   vfill_set;
  logic               vfill_en;
  logic [BANK_W-1:0]  vfill_bank;

  cpa_store #(.ENTRIES(LINES), .WIDTH(ENTRY_W)) i_store (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  cpa_victim #(.BANKS(BANKS), .SETS(SETS)) i_victim (
    .clk       (clk),
    .rst       (rst),
    .lk_line   (lk_line),
    .lk_valid  (lk_valid),
    .fill_set  (vfill_set),
    .fill_en   (vfill_en),
    .fill_bank (vfill_bank)
  );

  cpa_ctrl #(
    .BANKS(BANKS), .SETS(SETS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SWAP_EN(SWAP_EN)
  ) i_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_probes     (rsp_probes),
    .rsp_data       (rsp_data),
    .fill_req_valid (fill_req_valid),
    .fill_req_addr  (fill_req_addr),
    .fill_rsp_valid (fill_rsp_valid),
    .fill_rsp_data  (fill_rsp_data),
    .mem_wr_valid   (mem_wr_valid),
    .mem_wr_addr    (mem_wr_addr),
    .mem_wr_data    (mem_wr_data),
    .ram_we         (ram_we),
    .ram_addr       (ram_addr),
    .ram_wdata      (ram_wdata),
    .ram_rdata      (ram_rdata),
    .lk_line        (lk_line),
    .lk_valid       (lk_valid),
    .vfill_set      (vfill_set),
    .vfill_en       (vfill_en),
    .vfill_bank     (vfill_bank)
  );
endmodule

// File: tb/test_pseudo_assoc_cache.sv
`timescale 1ns/1ps
module test_pseudo_assoc_cache;
  localparam int LINES = 16;
  localparam int BANKS = 4;
  localparam int SETS  = LINES / BANKS;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int PW    = $clog2(BANKS + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_hit;
  logic [PW-1:0] rsp_probes;
  logic [DW-1:0] rsp_data;
  logic          fill_req_valid;
  logic [AW-1:0] fill_req_addr;
  logic          fill_rsp_valid = 1'b0;
  logic [DW-1:0] fill_rsp_data = '0;
  logic          mem_wr_valid;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  always #5 clk = ~clk;

  pseudo_assoc_cache #(
    .LINES(LINES), .BANKS(BANKS), .ADDR_W(AW), .DATA_W(DW), .SWAP_EN(1'b1)
  ) i_pseudo_assoc_cache (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_probes(rsp_probes), .rsp_data(rsp_data),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] memv [256];
  int m_tag [SETS][BANKS];
  bit m_vld [SETS][BANKS];
  int m_rr  [SETS];
  int fill_cnt = 0;
  logic [AW-1:0] last_fill_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Next-level memory: answers a fill two cycles after seeing it.
  initial begin
    forever begin
      @(negedge clk);
      if (fill_req_valid && !fill_rsp_valid) begin
        last_fill_addr = fill_req_addr;
        fill_cnt++;
        @(negedge clk);
        @(negedge clk);
        fill_rsp_data  = memv[last_fill_addr];
        fill_rsp_valid = 1'b1;
        @(negedge clk);
        fill_rsp_valid = 1'b0;
      end
    end
  end

  // One access: expected values from the placement table and memory image.
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    int set, tag, hb, exp_probes, cycles, f0, vb;
    bit exp_hit, full;
    logic [DW-1:0] exp_data;
    set = int'(a) % SETS;
    tag = int'(a) / SETS;
    hb = -1;
    for (int b = 0; b < BANKS; b++)
      if (hb < 0 && m_vld[set][b] && m_tag[set][b] == tag) hb = b;
    exp_hit    = (hb >= 0);
    exp_probes = exp_hit ? hb + 1 : BANKS;
    exp_data   = wr ? wd : memv[a];
    if (!wr && exp_hit && hb > 0) begin
      m_tag[set][hb] = m_tag[set][0];
      m_tag[set][0]  = tag;
    end
    if (!wr && !exp_hit) begin
      vb = -1;
      for (int b = 0; b < BANKS; b++)
        if (vb < 0 && !m_vld[set][b]) vb = b;
      full = (vb < 0);
      if (full) begin
        vb = m_rr[set];
        m_rr[set] = (m_rr[set] + 1) % BANKS;
      end
      m_vld[set][vb] = 1'b1;
      m_tag[set][vb] = tag;
    end

    f0 = fill_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cycles = 0;
    while (!rsp_valid && cycles < 200) begin
      @(negedge clk);
      cycles++;
    end
    chk(rsp_valid, "R8", "response seen", int'(rsp_valid), 1);
    chk(rsp_hit == exp_hit, "R3 R4", "hit flag", int'(rsp_hit), int'(exp_hit));
    chk(int'(rsp_probes) == exp_probes, "R2 R3 R5 R6", "probe count",
        int'(rsp_probes), exp_probes);
    chk(rsp_data == exp_data, "R9", "data", int'(rsp_data), int'(exp_data));
    if (exp_hit)
      chk(cycles == exp_probes, "R3", "hit latency", cycles, exp_probes);
    if (!wr && !exp_hit) begin
      chk(fill_cnt == f0 + 1, "R4", "fill issued", fill_cnt - f0, 1);
      chk(last_fill_addr == a, "R4", "fill addr", int'(last_fill_addr), int'(a));
    end else begin
      chk(fill_cnt == f0, "R7", "no fill", fill_cnt - f0, 0);
    end
    if (wr) begin
      chk(mem_wr_valid && mem_wr_addr == a && mem_wr_data == wd, "R7", "write-through",
          int'(mem_wr_data), int'(wd));
      memv[a] = wd;
    end else begin
      chk(!mem_wr_valid, "R7", "no write strobe on read", int'(mem_wr_valid), 0);
    end
    if (!wr && exp_hit && hb > 0) begin
      chk(!req_ready, "R6", "busy during swap", int'(req_ready), 0);
      @(negedge clk);
      chk(!req_ready, "R6", "busy during swap 2", int'(req_ready), 0);
    end else begin
      chk(req_ready, "R8", "ready at response", int'(req_ready), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 256; i++) memv[i] = DW'(i * 37 + 16'h1200);
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int b = 0; b < BANKS; b++) begin
        m_vld[s][b] = 1'b0;
        m_tag[s][b] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);
    chk(!rsp_valid, "R1", "no response after reset", int'(rsp_valid), 0);
    chk(!fill_req_valid, "R1", "no fill after reset", int'(fill_req_valid), 0);
    chk(!mem_wr_valid, "R1", "no write after reset", int'(mem_wr_valid), 0);

    // Directed walk in set 1: cold fills into banks 0..3 (R1, R5)
    for (int t = 0; t < 4; t++) access(1'b0, AW'(t * SETS + 1), '0);
    access(1'b0, AW'(3 * SETS + 1), '0);  // hit bank 3, swap (R6)
    access(1'b0, AW'(3 * SETS + 1), '0);  // now one probe (R6)
    access(1'b0, AW'(0 * SETS + 1), '0);  // moved to bank 3
    access(1'b0, AW'(5 * SETS + 1), '0);  // replacement (R5)
    access(1'b0, AW'(6 * SETS + 1), '0);
    access(1'b1, AW'(3 * SETS + 1), 16'hBEEF); // write hit (R7)
    access(1'b0, AW'(3 * SETS + 1), '0);       // read back (R9)
    access(1'b1, AW'(9 * SETS + 1), 16'h5A5A); // write miss, no allocation (R7)
    access(1'b0, AW'(9 * SETS + 1), '0);       // still misses (R7)

    // Sweep: all sets, eight tags each, mixed reads and writes
    lfsr = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      logic [AW-1:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {3'b000, lfsr[4:0]};
      access(lfsr[7:5] == 3'b000, a, lfsr ^ 16'h3C3C);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule